// File: doc/BRIEF.md
# Hot-swap sequencing and fault controller

This block is the digital control core of a hot-swap power switch. It sits behind analog comparators that are already reduced to clean synchronous flags: supply undervoltage, supply overvoltage, output power-good, current limit active, short circuit, and a deep-undervoltage reset. Two control pins are also inputs. The on-request pin starts and stops the switch with its edges. The board-absent pin keeps the switch off while it is high. The block decides when the external gate driver is enabled and runs the start-up window and the overcurrent back-off window from a slow tick. It keeps a sticky fault register and drives an active-low alert and a power-good indicator pin.

A small write port gives access to three registers. The control register holds the switch-request bit, the auto-retry enable and the indicator mode. The alert-mask register selects which faults pull the alert low. The fault register can be cleared bit by bit. The start-up window lasts `START_TICKS` ticks and the retry back-off lasts `START_TICKS * RETRY_MULT` ticks, which gives a 1:50 on/off ratio with the default multiplier.

Top module: `hotswap_ctrl`

## Requirements
- R1: A rising edge on `on_pin` sets control bit 0 (switch request) one cycle later and, if nothing blocks it, raises `gate_en` two cycles after the edge. A falling edge clears bit 0 one cycle later and drops `gate_en` two cycles after the edge.
- R2: After reset the gate stays off for `START_TICKS` ticks. Control bit 0 then takes the level of `on_pin`. If that level is low, the switch stays off until bit 0 is written to 1 through the control register.
- R3: A falling edge on `on_pin` clears every fault bit, except those raised by events in that same cycle.
- R4: While `brd_off` is high, `gate_en` is low. Each change of `brd_off` sets fault bit 4. A falling edge of `brd_off` copies the `on_pin` level into control bit 0 and clears every other fault bit.
- R5: `ov_flag` sets fault bit 0 and `uv_flag` sets fault bit 1. Either flag forces `gate_en` low in the next cycle. Once the flag is gone, the gate resumes on its own if bit 0 is still set.
- R6: `uv_reset` clears all fault bits in the next cycle, overriding every other event. It also aborts a pending retry back-off, so no automatic restart follows.
- R7: Fault bit 3 (power bad) is set only while the start-up window has finished with the gate on and `pg_flag` is low. It is never set during start-up or while the switch is off.
- R8: If `ilim_flag` is high when the start-up window of `START_TICKS` ticks ends, fault bit 2 is set, control bit 0 is cleared and `gate_en` drops. Without a `tick`, the window does not advance.
- R9: With control bit 1 (auto-retry) set, an overcurrent is followed by `START_TICKS*RETRY_MULT` ticks with the gate off. Control bit 0 is then set again and the start-up is repeated.
- R10: `short_flag` while the gate is on sets fault bit 2, clears control bit 0 and drops `gate_en` in the next cycle.
- R11: `alert_n` is low exactly when some fault bit and the same bit of the alert mask are both 1. The mask is 0 after reset.
- R12: Control bits 3:2 select `gpio_low`. 00 pulls low while `pg_flag` is low (the reset default). 01 pulls low while `pg_flag` is high. 10 always releases. 11 always pulls low.
- R13: `reg_sel` 0 writes the control register, 1 writes the alert mask, and 2 ANDs the fault register with the data, so a 0 bit clears that fault. A fault raised in the same cycle as a clearing write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe for start-up and retry windows |
| on_pin | input | 1 | On-request pin (edges and level) |
| brd_off | input | 1 | Board-absent pin, high blocks the switch |
| uv_flag | input | 1 | Supply undervoltage flag |
| ov_flag | input | 1 | Supply overvoltage flag |
| pg_flag | input | 1 | Output power good |
| ilim_flag | input | 1 | Current limit active |
| short_flag | input | 1 | Short circuit detected |
| uv_reset | input | 1 | Deep undervoltage reset request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 mask, 2 fault |
| reg_wdata | input | 5 | Register write data |
| gate_en | output | 1 | Gate driver enable |
| alert_n | output | 1 | Alert, active low |
| gpio_low | output | 1 | Indicator pin pull-low request |
| fault_q | output | 5 | Fault register: 0 OV, 1 UV, 2 OC, 3 power bad, 4 board change |
| ctrl_q | output | 4 | Control register: 0 switch request, 1 auto-retry, 3:2 indicator mode |

## Verification
Pin and flag effects on the registers (fault bits, control bits, alert) appear one clock after the stimulus. `gate_en` follows a flag that blocks it one clock later, and follows an `on_pin` edge two clocks later, because the edge first lands in control bit 0. The start-up window ends on the fourth ticking edge after the gate comes on. The retry back-off ends on edge 200 after the overcurrent, with the gate returning one edge after that, and `gpio_low` responds within the cycle. The bench applies inputs on the falling clock edge and reads the outputs on a later falling edge after exactly that many rising edges. It reads one cycle before and one cycle after each expected change.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;

    localparam int FLT_W  = 5;
    localparam int CTRL_W = 4;
    localparam int WR_W   = FLT_W;

    localparam int F_OV = 0;
    localparam int F_UV = 1;
    localparam int F_OC = 2;
    localparam int F_PB = 3;
    localparam int F_EN = 4;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_OFF,
        ST_START,
        ST_ON,
        ST_RETRY
    } hs_state_e;

    typedef enum logic [1:0] {
        GP_LOW_ON_BAD  = 2'b00,
        GP_LOW_ON_GOOD = 2'b01,
        GP_RELEASE     = 2'b10,
        GP_FORCE_LOW   = 2'b11
    } hs_gpio_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_FAULT = 2'd2
    } hs_sel_e;

    typedef struct packed {
        logic [1:0] gpio_mode;
        logic       autoretry;
        logic       fet_on;
    } hs_ctrl_t;

    typedef struct packed {
        logic oc_evt;
        logic retry_done;
        logic pwrup_done;
    } hs_seq_evt_t;

    function automatic logic gpio_pull(input logic [1:0] mode, input logic pg);
        case (hs_gpio_mode_e'(mode))
            GP_LOW_ON_BAD:  return ~pg;
            GP_LOW_ON_GOOD: return pg;
            GP_RELEASE:     return 1'b0;
            default:        return 1'b1;
        endcase
    endfunction

    function automatic logic gate_stage(input hs_state_e st);
        return (st == ST_START) || (st == ST_ON);
    endfunction

endpackage

// File: rtl/hs_pin_edges.sv
`timescale 1ns/1ps
module hs_pin_edges #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pins,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    // During reset the history follows the pins, so release brings no edge.
    always_ff @(posedge clk) begin
        prev_q <= pins;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = pins[i] & ~prev_q[i] & ~rst;
        assign fall[i] = ~pins[i] & prev_q[i] & ~rst;
    end
endmodule

// File: rtl/hs_tick_timer.sv
`timescale 1ns/1ps
module hs_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = run & tick & (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/hs_seq_fsm.sv
`timescale 1ns/1ps
module hs_seq_fsm
    import hs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        gate_req,
    input  logic        ilim_flag,
    input  logic        short_flag,
    input  logic        uv_reset,
    input  logic        autoretry,
    input  logic        tmr_done,
    output hs_state_e   state,
    output logic        tmr_run,
    output logic        tmr_clr,
    output logic        tmr_long,
    output hs_seq_evt_t evt
);
    hs_state_e state_n;
    hs_state_e oc_dest;

    assign oc_dest = autoretry ? ST_RETRY : ST_OFF;

    always_comb begin
        state_n = state;
        evt     = '0;
        unique case (state)
            ST_PWRUP: begin
                if (tmr_done) begin
                    state_n        = ST_OFF;
                    evt.pwrup_done = 1'b1;
                end
            end
            ST_OFF: begin
                if (gate_req) state_n = ST_START;
            end
            ST_START: begin
                if (short_flag) begin
                    evt.oc_evt = 1'b1;
                    state_n    = oc_dest;
                end else if (!gate_req) begin
                    state_n = ST_OFF;
                end else if (tmr_done) begin
                    if (ilim_flag) begin
                        evt.oc_evt = 1'b1;
                        state_n    = oc_dest;
                    end else begin
                        state_n = ST_ON;
                    end
                end
            end
            ST_ON: begin
                if (short_flag) begin
                    evt.oc_evt = 1'b1;
                    state_n    = oc_dest;
                end else if (!gate_req) begin
                    state_n = ST_OFF;
                end
            end
            ST_RETRY: begin
                if (uv_reset) begin
                    state_n = ST_OFF;
                end else if (tmr_done) begin
                    state_n        = ST_OFF;
                    evt.retry_done = 1'b1;
                end
            end
            default: state_n = ST_OFF;
        endcase
    end

    assign tmr_run  = (state == ST_PWRUP) || (state == ST_START) || (state == ST_RETRY);
    assign tmr_long = (state == ST_RETRY);
    assign tmr_clr  = (state_n != state);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_PWRUP;
        else     state <= state_n;
    end
endmodule

// File: rtl/hs_fault_log.sv
`timescale 1ns/1ps
module hs_fault_log
    import hs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [FLT_W-1:0] wr_keep,
    input  logic             clr_soft,
    input  logic             clr_hard,
    input  logic [FLT_W-1:0] set_vec,
    output logic [FLT_W-1:0] fault_q
);
    logic [FLT_W-1:0] fault_n;

    // Order: software clear, pin clear, new events, deep reset.
    always_comb begin
        fault_n = fault_q;
        if (wr_en)    fault_n = fault_n & wr_keep;
        if (clr_soft) fault_n = '0;
        fault_n = fault_n | set_vec;
        if (clr_hard) fault_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) fault_q <= '0;
        else     fault_q <= fault_n;
    end
endmodule

// File: rtl/hotswap_ctrl.sv
`timescale 1ns/1ps
module hotswap_ctrl
    import hs_pkg::*;
#(
    parameter int START_TICKS = 100,
    parameter int RETRY_MULT  = 50
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic                      on_pin,
    input  logic                      brd_off,
    input  logic                      uv_flag,
    input  logic                      ov_flag,
    input  logic                      pg_flag,
    input  logic                      ilim_flag,
    input  logic                      short_flag,
    input  logic                      uv_reset,
    input  logic                      reg_wr,
    input  logic [1:0]                reg_sel,
    input  logic [hs_pkg::WR_W-1:0]   reg_wdata,
    output logic                      gate_en,
    output logic                      alert_n,
    output logic                      gpio_low,
    output logic [hs_pkg::FLT_W-1:0]  fault_q,
    output logic [hs_pkg::CTRL_W-1:0] ctrl_q
);
    localparam int RETRY_TICKS = START_TICKS * RETRY_MULT;
    localparam int CNT_W       = $clog2(RETRY_TICKS + 1);
    localparam int PIN_ON      = 0;
    localparam int PIN_EN      = 1;

    logic [1:0]       pin_rise, pin_fall;
    hs_ctrl_t         ctrl_r, ctrl_n;
    logic [FLT_W-1:0] mask_r;
    logic [FLT_W-1:0] set_vec;
    hs_state_e        state;
    hs_seq_evt_t      evt;
    logic             gate_req;
    logic             tmr_run, tmr_clr, tmr_long, tmr_done;
    logic [CNT_W-1:0] tmr_limit;
    logic             on_rise, on_fall, en_fall, en_change;

    hs_pin_edges #(.N(2)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .pins ({brd_off, on_pin}),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign on_rise   = pin_rise[PIN_ON];
    assign on_fall   = pin_fall[PIN_ON];
    assign en_fall   = pin_fall[PIN_EN];
    assign en_change = pin_rise[PIN_EN] | pin_fall[PIN_EN];

    assign gate_req = ctrl_r.fet_on & ~brd_off & ~ov_flag & ~uv_flag & ~uv_reset;

    hs_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .gate_req   (gate_req),
        .ilim_flag  (ilim_flag),
        .short_flag (short_flag),
        .uv_reset   (uv_reset),
        .autoretry  (ctrl_r.autoretry),
        .tmr_done   (tmr_done),
        .state      (state),
        .tmr_run    (tmr_run),
        .tmr_clr    (tmr_clr),
        .tmr_long   (tmr_long),
        .evt        (evt)
    );

    assign tmr_limit = tmr_long ? CNT_W'(RETRY_TICKS) : CNT_W'(START_TICKS);

    hs_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .run   (tmr_run),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    always_comb begin
        set_vec       = '0;
        set_vec[F_OV] = ov_flag;
        set_vec[F_UV] = uv_flag;
        set_vec[F_OC] = evt.oc_evt;
        set_vec[F_PB] = (state == ST_ON) & ~pg_flag;
        set_vec[F_EN] = en_change;
    end

    hs_fault_log u_faults (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr && (reg_sel == SEL_FAULT)),
        .wr_keep  (reg_wdata),
        .clr_soft (on_fall | en_fall),
        .clr_hard (uv_reset),
        .set_vec  (set_vec),
        .fault_q  (fault_q)
    );

    // Later lines take priority: pins over software, sequencer over pins.
    always_comb begin
        ctrl_n = ctrl_r;
        if (reg_wr && (reg_sel == SEL_CTRL)) ctrl_n = hs_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (on_rise)        ctrl_n.fet_on = 1'b1;
        if (on_fall)        ctrl_n.fet_on = 1'b0;
        if (en_fall)        ctrl_n.fet_on = on_pin;
        if (evt.pwrup_done) ctrl_n.fet_on = on_pin;
        if (evt.oc_evt)     ctrl_n.fet_on = 1'b0;
        if (evt.retry_done) ctrl_n.fet_on = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r <= '0;
            mask_r <= '0;
        end else begin
            ctrl_r <= ctrl_n;
            if (reg_wr && (reg_sel == SEL_MASK)) mask_r <= reg_wdata;
        end
    end

    assign ctrl_q   = ctrl_r;
    assign gate_en  = gate_stage(state);
    assign alert_n  = ~|(fault_q & mask_r);
    assign gpio_low = gpio_pull(ctrl_r.gpio_mode, pg_flag);
endmodule

// File: rtl/hs_ctrl_chk.sv
`timescale 1ns/1ps
module hs_ctrl_chk
    import hs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             brd_off,
    input logic             ov_flag,
    input logic             uv_flag,
    input logic             uv_reset,
    input logic             short_flag,
    input logic             reg_wr,
    input logic             gate_en,
    input logic             alert_n,
    input logic [FLT_W-1:0] fault_q,
    input logic [FLT_W-1:0] mask_q,
    input hs_state_e        st
);
    a_r4_board_blocks_gate: assert property (@(posedge clk) disable iff (rst)
        brd_off |=> !gate_en);

    a_r5_ov_gate_off: assert property (@(posedge clk) disable iff (rst)
        ov_flag |=> !gate_en);

    a_r5_uv_gate_off: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> !gate_en);

    a_r6_deep_reset_clears: assert property (@(posedge clk) disable iff (rst)
        uv_reset |=> (fault_q == '0));

    a_r10_short_trips: assert property (@(posedge clk) disable iff (rst)
        (short_flag && gate_en && !uv_reset) |=> (!gate_en && fault_q[F_OC]));

    a_r11_alert_on_masked_ov: assert property (@(posedge clk) disable iff (rst)
        (ov_flag && mask_q[F_OV] && !uv_reset && !reg_wr) |=> !alert_n);

    a_r7_pb_only_when_on: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q[F_PB]) |-> $past(st == ST_ON));
endmodule

bind hotswap_ctrl hs_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .brd_off    (brd_off),
    .ov_flag    (ov_flag),
    .uv_flag    (uv_flag),
    .uv_reset   (uv_reset),
    .short_flag (short_flag),
    .reg_wr     (reg_wr),
    .gate_en    (gate_en),
    .alert_n    (alert_n),
    .fault_q    (fault_q),
    .mask_q     (mask_r),
    .st         (state)
);

// File: tb/tb_hotswap_ctrl.sv
`timescale 1ns/1ps
module tb_hotswap_ctrl;
    localparam int ST = 4;
    localparam int RM = 50;

    logic clk = 1'b0;
    logic rst, tick, on_pin, brd_off, uv_flag, ov_flag, pg_flag;
    logic ilim_flag, short_flag, uv_reset, reg_wr;
    logic [1:0] reg_sel;
    logic [4:0] reg_wdata;
    logic gate_en, alert_n, gpio_low;
    logic [4:0] fault_q;
    logic [3:0] ctrl_q;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hotswap_ctrl #(.START_TICKS(ST), .RETRY_MULT(RM)) dut (
        .clk(clk), .rst(rst), .tick(tick), .on_pin(on_pin), .brd_off(brd_off),
        .uv_flag(uv_flag), .ov_flag(ov_flag), .pg_flag(pg_flag),
        .ilim_flag(ilim_flag), .short_flag(short_flag), .uv_reset(uv_reset),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .gate_en(gate_en), .alert_n(alert_n), .gpio_low(gpio_low),
        .fault_q(fault_q), .ctrl_q(ctrl_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [4:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic do_reset(input logic on_lvl);
        @(negedge clk);
        rst = 1'b1; tick = 1'b1; on_pin = on_lvl; brd_off = 1'b0;
        uv_flag = 1'b0; ov_flag = 1'b0; pg_flag = 1'b1; ilim_flag = 1'b0;
        short_flag = 1'b0; uv_reset = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0;
        reg_wdata = '0;
        step(3);
        check("R2 reset gate", gate_en, 0);
        check("R2 reset fault", fault_q, 0);
        check("R2 reset ctrl", ctrl_q, 0);
        check("R11 reset alert", alert_n, 1);
        rst = 1'b0;
    endtask

    task automatic t_r2_powerup();
        do_reset(1'b1);
        step(ST - 1);
        check("R2 request before window end", ctrl_q[0], 0);
        step(1);
        check("R2 request loaded from high pin", ctrl_q[0], 1);
        check("R2 gate one cycle later still off", gate_en, 0);
        step(1);
        check("R2 gate on after power-up", gate_en, 1);
        do_reset(1'b0);
        step(10);
        check("R2 low pin keeps switch off", gate_en, 0);
        check("R2 low pin keeps request clear", ctrl_q[0], 0);
        wr(2'd0, 5'h01);
        check("R2 register write sets request", ctrl_q[0], 1);
        step(1);
        check("R2 gate on after register write", gate_en, 1);
    endtask

    task automatic t_r1_on_edges();
        do_reset(1'b0);
        step(ST);
        on_pin = 1'b1; step(1);
        check("R1 rise sets request", ctrl_q[0], 1);
        check("R1 gate not yet on", gate_en, 0);
        step(1);
        check("R1 gate on two cycles after rise", gate_en, 1);
        on_pin = 1'b0; step(1);
        check("R1 fall clears request", ctrl_q[0], 0);
        check("R1 gate still on one cycle after fall", gate_en, 1);
        step(1);
        check("R1 gate off two cycles after fall", gate_en, 0);
    endtask

    task automatic t_r3_on_fall_clears();
        do_reset(1'b0);
        step(ST);
        ov_flag = 1'b1; step(1); ov_flag = 1'b0;
        check("R3 fault present before fall", fault_q, 5'h01);
        on_pin = 1'b1; step(1);
        check("R3 rise leaves faults", fault_q, 5'h01);
        on_pin = 1'b0; step(1);
        check("R3 fall clears faults", fault_q, 5'h00);
    endtask

    task automatic t_r4_board();
        do_reset(1'b0);
        step(ST);
        brd_off = 1'b1; step(1);
        check("R4 board change logged", fault_q, 5'h10);
        ov_flag = 1'b1; step(1); ov_flag = 1'b0;
        wr(2'd0, 5'h01);
        check("R4 request set while absent", ctrl_q[0], 1);
        step(3);
        check("R4 gate blocked while absent", gate_en, 0);
        brd_off = 1'b0; step(1);
        check("R4 fall copies low pin level", ctrl_q[0], 0);
        check("R4 fall clears others keeps change bit", fault_q, 5'h10);
        on_pin = 1'b1; step(2);
        check("R4 gate on once present", gate_en, 1);
    endtask

    task automatic t_r5_r6_supply();
        do_reset(1'b0);
        step(ST);
        on_pin = 1'b1; step(2);
        check("R5 gate on before overvoltage", gate_en, 1);
        ov_flag = 1'b1; step(1);
        check("R5 overvoltage gate off", gate_en, 0);
        check("R5 overvoltage logged", fault_q, 5'h01);
        ov_flag = 1'b0; step(1);
        check("R5 gate resumes after overvoltage", gate_en, 1);
        uv_flag = 1'b1; step(1);
        check("R5 undervoltage gate off", gate_en, 0);
        check("R5 undervoltage logged", fault_q, 5'h03);
        uv_flag = 1'b0;
        uv_reset = 1'b1; step(1); uv_reset = 1'b0;
        check("R6 deep reset clears faults", fault_q, 5'h00);
    endtask

    task automatic t_r8_overcurrent();
        do_reset(1'b0);
        step(ST);
        ilim_flag = 1'b1; on_pin = 1'b1;
        step(5);
        check("R8 gate on in last window cycle", gate_en, 1);
        check("R8 no fault before expiry", fault_q, 0);
        step(1);
        check("R8 gate off at expiry", gate_en, 0);
        check("R8 overcurrent logged", fault_q, 5'h04);
        check("R8 request cleared", ctrl_q[0], 0);
        step(10);
        check("R8 stays off without retry", gate_en, 0);
        do_reset(1'b0);
        step(ST);
        ilim_flag = 1'b1; tick = 1'b0; on_pin = 1'b1;
        step(20);
        check("R8 window frozen without tick", gate_en, 1);
        check("R8 no fault without tick", fault_q, 0);
        tick = 1'b1; step(3);
        check("R8 gate on after three ticks", gate_en, 1);
        step(1);
        check("R8 expiry on fourth tick", fault_q, 5'h04);
    endtask

    task automatic t_r9_retry();
        do_reset(1'b0);
        step(ST);
        wr(2'd0, 5'h02);
        ilim_flag = 1'b1; on_pin = 1'b1;
        step(6);
        check("R9 overcurrent trips", gate_en, 0);
        ilim_flag = 1'b0;
        step(ST * RM - 1);
        check("R9 still off before back-off end", gate_en, 0);
        check("R9 request clear during back-off", ctrl_q[0], 0);
        check("R9 fault held during back-off", fault_q, 5'h04);
        step(1);
        check("R9 request set at back-off end", ctrl_q[0], 1);
        check("R9 gate off at back-off end", gate_en, 0);
        step(1);
        check("R9 gate restarts", gate_en, 1);
        do_reset(1'b0);
        step(ST);
        wr(2'd0, 5'h02);
        ilim_flag = 1'b1; on_pin = 1'b1;
        step(6);
        ilim_flag = 1'b0;
        step(20);
        uv_reset = 1'b1; step(1); uv_reset = 1'b0;
        check("R6 deep reset clears during back-off", fault_q, 0);
        step(ST * RM + 50);
        check("R6 aborted back-off no restart", gate_en, 0);
        check("R6 aborted back-off request clear", ctrl_q[0], 0);
    endtask

    task automatic t_r10_short();
        do_reset(1'b0);
        step(ST);
        on_pin = 1'b1; step(2);
        short_flag = 1'b1; step(1); short_flag = 1'b0;
        check("R10 short gate off", gate_en, 0);
        check("R10 short logs overcurrent", fault_q, 5'h04);
        check("R10 short clears request", ctrl_q[0], 0);
    endtask

    task automatic t_r7_power_bad();
        do_reset(1'b0);
        step(ST);
        pg_flag = 1'b0; step(3);
        check("R7 no power bad while off", fault_q, 0);
        on_pin = 1'b1; step(6);
        check("R7 no power bad during start-up", fault_q, 0);
        check("R7 gate on", gate_en, 1);
        step(1);
        check("R7 power bad after start-up", fault_q, 5'h08);
    endtask

    task automatic t_r11_r13_regs();
        do_reset(1'b0);
        step(ST);
        ov_flag = 1'b1; step(1); ov_flag = 1'b0;
        check("R11 masked fault no alert", alert_n, 1);
        wr(2'd1, 5'h01);
        check("R11 unmasked fault alerts", alert_n, 0);
        wr(2'd2, 5'h1E);
        check("R13 write zero clears bit", fault_q, 0);
        check("R11 alert released", alert_n, 1);
        wr(2'd1, 5'h02);
        ov_flag = 1'b1; step(1); ov_flag = 1'b0;
        check("R11 other bit masked", alert_n, 1);
        uv_flag = 1'b1; step(1); uv_flag = 1'b0;
        check("R11 matching bit alerts", alert_n, 0);
        brd_off = 1'b1; step(1); brd_off = 1'b0; step(1);
        check("R13 setup change bit", fault_q, 5'h10);
        ov_flag = 1'b1;
        wr(2'd2, 5'h00);
        ov_flag = 1'b0;
        check("R13 same-cycle event beats clear", fault_q, 5'h01);
    endtask

    task automatic t_r12_gpio();
        do_reset(1'b0);
        step(ST);
        pg_flag = 1'b0; step(1);
        check("R12 mode 00 low when bad", gpio_low, 1);
        pg_flag = 1'b1; step(1);
        check("R12 mode 00 released when good", gpio_low, 0);
        wr(2'd0, 5'h04);
        check("R12 mode 01 low when good", gpio_low, 1);
        pg_flag = 1'b0; step(1);
        check("R12 mode 01 released when bad", gpio_low, 0);
        wr(2'd0, 5'h08);
        check("R12 mode 10 released", gpio_low, 0);
        wr(2'd0, 5'h0C);
        pg_flag = 1'b1; step(1);
        check("R12 mode 11 always low", gpio_low, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin
        t_r2_powerup();
        t_r1_on_edges();
        t_r3_on_fall_clears();
        t_r4_board();
        t_r5_r6_supply();
        t_r8_overcurrent();
        t_r9_retry();
        t_r10_short();
        t_r7_power_bad();
        t_r11_r13_regs();
        t_r12_gpio();
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule